// File: doc/BRIEF.md
# Indirect-Select Event Counter Bank

This block holds a bank of wide event counters that software controls over a simple 32-bit register bus. Each counter has a configuration register. It chooses one line from a vector of event inputs. It also sets whether the counter counts cycles while the line is active or counts transitions into the active state, and whether active means high or low. A single control register starts, stops and clears the whole bank.

Counter values are never mapped directly. Software first writes the index of a counter, offset by eight, into a select register. That write captures the counter's full 64-bit value into a holding register. Software then reads the lower and upper halves of the held value from two fixed window addresses. Both halves therefore come from the same clock edge, even while the counter keeps running.

The bus has write and read strobes. A read returns data one cycle after its strobe, marked by `bus_rvalid`. The bus has no stall, and every access completes in one cycle. The event inputs are plain level signals that are sampled on every clock.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every register reads zero, every counter holds zero and `bus_rvalid` is low.
- R2: A read strobe in one cycle gives `bus_rvalid` high with the addressed data on `bus_rdata` in the next cycle. Any address that is not decoded reads zero.
- R3: Control register at 0x108. Bit 0 is enable and bit 1 is start; both read back. Counters advance only while both are set. Writing zero freezes every counter at its current value.
- R4: Writing the control register with bit 4 set clears every counter at that edge. Bit 4 always reads zero. If the same write sets enable and start, counting resumes from the next cycle.
- R5: The configuration register of counter n is at 0x10C + 4*n. Its bits [11:0] are read/write. Bits above 11 read zero.
- R6: With configuration bit 11 clear (level mode), a running counter gains one on every cycle in which its chosen event is active.
- R7: With configuration bit 11 set (edge mode), a running counter gains one on each change of its event from inactive to active. An event held active for many cycles counts once.
- R8: Configuration bit 10 set makes the input active when high (rising transitions). Bit 10 clear makes it active when low (falling transitions).
- R9: Configuration bits [9:0] give the event id, which indexes `evt_in`. An id of 512 or more selects no event, and that counter never advances.
- R10: Writing 8+n to the select register at 0x12C captures the value counter n held just before that edge. The captured value reads at 0x130 (bits 31:0) and 0x134 (bits 63:32). It stays unchanged until the next select write.
- R11: The select register reads back the value written to it. A select value outside 8..15 makes both window addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| evt_in | input | 512 | Event lines, indexed by event id |

## Verification
A wrong count shows up only when software selects the counter and reads a window. A counter that drifts while stopped, or picks the wrong event line, stays hidden until the next select write and window read. The directed scenarios therefore always end with a select and a read. Each scenario counts edges exactly, so an error of a single count is caught. A snapshot that does not hold still, or a bad select that leaks stale data, is visible on the very next window read. The bound checks catch a counter that moves while stopped or steps by more than one on the edge where it happens.

// File: rtl/evcnt_pkg.sv
`timescale 1ns/1ps
package evcnt_pkg;
  localparam logic [11:0] OFS_CTRL = 12'h108;
  localparam logic [11:0] OFS_CFG0 = 12'h10C;
  localparam logic [11:0] OFS_SEL  = 12'h12C;
  localparam logic [11:0] OFS_WLO  = 12'h130;
  localparam logic [11:0] OFS_WHI  = 12'h134;

  localparam int CTRL_EN_B  = 0;
  localparam int CTRL_GO_B  = 1;
  localparam int CTRL_CLR_B = 4;
  localparam int CFG_W      = 12;

  // bit 11: edge mode, bit 10: active-high, bits 9:0: event id
  typedef struct packed {
    logic       edge_mode;
    logic       pol_hi;
    logic [9:0] ev_id;
  } ctr_cfg_t;
endpackage

// File: rtl/evcnt_event_sense.sv
`timescale 1ns/1ps
module evcnt_event_sense
  import evcnt_pkg::*;
#(
  parameter int EVT_N = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_in,
  input  ctr_cfg_t         cfg,
  output logic             hit
);
  localparam int IX_W = (EVT_N > 1) ? $clog2(EVT_N) : 1;

  logic [IX_W-1:0] ix;
  logic            in_range;
  logic            act;
  logic            prev_q;

  assign ix       = IX_W'(cfg.ev_id);
  assign in_range = 32'(cfg.ev_id) < 32'(EVT_N);
  // active level after polarity, forced off for ids outside the vector
  assign act      = in_range & (evt_in[ix] ~^ cfg.pol_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= act;
  end

  assign hit = cfg.edge_mode ? (act & ~prev_q) : act;
endmodule

// File: rtl/evcnt_count.sv
`timescale 1ns/1ps
module evcnt_count #(
  parameter int CTR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CTR_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CTR_W'(1);
  end
endmodule

// File: rtl/evcnt_readout.sv
`timescale 1ns/1ps
module evcnt_readout #(
  parameter int NUM_CTR  = 8,
  parameter int CTR_W    = 64,
  parameter int SEL_BASE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_wr,
  input  logic [31:0]                   sel_val,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
  output logic [31:0]                   sel_q,
  output logic                          sel_ok,
  output logic [63:0]                   snap
);
  localparam int CIX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  logic [31:0]      off;
  logic             ok;
  logic [CIX_W-1:0] idx;

  assign off = sel_val - 32'(SEL_BASE);
  assign ok  = off < 32'(NUM_CTR);
  assign idx = off[CIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      sel_ok <= 1'b0;
      snap   <= '0;
    end else if (sel_wr) begin
      sel_q  <= sel_val;
      sel_ok <= ok;
      snap   <= ok ? 64'(cnt_all[idx]) : 64'd0;
    end
  end
endmodule

// File: rtl/evcnt_bank.sv
`timescale 1ns/1ps
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR  = 8,
  parameter int CTR_W    = 64,
  parameter int EVT_N    = 512,
  parameter int SEL_BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [EVT_N-1:0] evt_in
);
  logic wr_ctrl, clr_now, sel_wr;
  logic en_q, go_q, run_q;
  ctr_cfg_t [NUM_CTR-1:0]          cfg_q;
  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt_all;
  logic [NUM_CTR-1:0]              hit;
  logic [31:0]                     sel_q;
  logic                            sel_ok;
  logic [63:0]                     snap;
  logic [31:0]                     rd_mux;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign clr_now = wr_ctrl && bus_wdata[CTRL_CLR_B];
  assign sel_wr  = bus_wr && (bus_addr == OFS_SEL);
  assign run_q   = en_q & go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      go_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= bus_wdata[CTRL_EN_B];
      go_q <= bus_wdata[CTRL_GO_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (bus_wr && (bus_addr == OFS_CFG0 + 12'(4*i)))
          cfg_q[i] <= ctr_cfg_t'(bus_wdata[CFG_W-1:0]);
      end
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    evcnt_event_sense #(.EVT_N(EVT_N)) u_sense (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .cfg    (cfg_q[g]),
      .hit    (hit[g])
    );
    evcnt_count #(.CTR_W(CTR_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_now),
      .inc   (run_q & hit[g]),
      .cnt   (cnt_all[g])
    );
  end

  evcnt_readout #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SEL_BASE(SEL_BASE)) u_rdout (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_wr  (sel_wr),
    .sel_val (bus_wdata),
    .cnt_all (cnt_all),
    .sel_q   (sel_q),
    .sel_ok  (sel_ok),
    .snap    (snap)
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_CTRL: rd_mux = 32'({go_q, en_q});
      OFS_SEL:  rd_mux = sel_q;
      OFS_WLO:  rd_mux = snap[31:0];
      OFS_WHI:  rd_mux = snap[63:32];
      default: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (bus_addr == OFS_CFG0 + 12'(4*i)) rd_mux = 32'(cfg_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/evcnt_bank_chk.sv
`timescale 1ns/1ps
module evcnt_bank_chk
  import evcnt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [11:0]                   bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          bus_rvalid,
  input logic                          run_q,
  input logic                          sel_ok,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all
);
  logic clr_seen;
  logic win_rd;
  assign clr_seen = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_CLR_B];
  assign win_rd   = bus_rd && !bus_wr && (bus_addr == OFS_WLO || bus_addr == OFS_WHI);

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R11
  badsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && !sel_ok) |=> bus_rdata == 32'd0);

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_c
    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_seen |=> cnt_all[g] == '0);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !clr_seen) |=> $stable(cnt_all[g]));
    // R6
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_seen |=> (cnt_all[g] - $past(cnt_all[g])) <= CTR_W'(1));
  end
endmodule

bind evcnt_bank evcnt_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .run_q      (run_q),
  .sel_ok     (sel_ok),
  .cnt_all    (cnt_all)
);

// File: tb/evcnt_bank_tb_top.sv
`timescale 1ns/1ps
module evcnt_bank_tb_top;
  localparam logic [11:0] A_CTRL = 12'h108;
  localparam logic [11:0] A_SEL  = 12'h12C;
  localparam logic [11:0] A_WLO  = 12'h130;
  localparam logic [11:0] A_WHI  = 12'h134;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [511:0] evt_in = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evcnt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_in(evt_in)
  );

  function automatic logic [11:0] cfg_a(input int n);
    return 12'h10C + 12'(4*n);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic peek(input int n, output logic [31:0] lo, output logic [31:0] hi);
    wr(A_SEL, 32'(8 + n));
    rd(A_WLO, lo);
    rd(A_WHI, hi);
  endtask

  task automatic pulse(input int id, input int cyc);
    @(negedge clk); evt_in[id] = 1'b1;
    repeat (cyc) @(posedge clk);
    @(negedge clk); evt_in[id] = 1'b0;
  endtask

  task automatic low_pulse(input int id, input int cyc);
    @(negedge clk); evt_in[id] = 1'b0;
    repeat (cyc) @(posedge clk);
    @(negedge clk); evt_in[id] = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rvalid after reset", 32'(bus_rvalid), 32'd0);
    rd(A_CTRL, d);  chk("R1 ctrl reset", d, 32'd0);
    chk("R2 rvalid after read", 32'(bus_rvalid), 32'd1);
    rd(cfg_a(0), d); chk("R1 cfg0 reset", d, 32'd0);
    rd(A_SEL, d);   chk("R1 sel reset", d, 32'd0);
    rd(A_WLO, d);   chk("R1 window lo reset", d, 32'd0);
    rd(A_WHI, d);   chk("R1 window hi reset", d, 32'd0);
    rd(12'h000, d); chk("R2 unmapped read", d, 32'd0);
    @(posedge clk); #1;
    chk("R2 rvalid idle", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] lo, hi;
    wr(cfg_a(0), 32'h0000_043D);
    wr(A_CTRL, 32'h13);
    pulse('h3D, 7);
    wr(A_CTRL, 32'h0);
    peek(0, lo, hi);
    chk("R6 level count lo", lo, 32'd7);
    chk("R10 level count hi", hi, 32'd0);
  endtask

  task automatic t_ctrl_gate();
    logic [31:0] lo, hi;
    pulse('h3D, 5);
    wr(A_CTRL, 32'h1);
    pulse('h3D, 4);
    wr(A_CTRL, 32'h2);
    pulse('h3D, 4);
    wr(A_CTRL, 32'h0);
    peek(0, lo, hi);
    chk("R3 no count unless enable and start", lo, 32'd7);
  endtask

  task automatic t_clear();
    logic [31:0] lo, hi, d;
    wr(A_CTRL, 32'h10);
    peek(0, lo, hi);
    chk("R4 clear while stopped", lo, 32'd0);
    rd(A_CTRL, d);
    chk("R4 ctrl after clear-only write", d, 32'd0);
    wr(A_CTRL, 32'h13);
    rd(A_CTRL, d);
    chk("R3 ctrl readback drops bit4", d, 32'h3);
    pulse('h3D, 4);
    wr(A_CTRL, 32'h0);
    peek(0, lo, hi);
    chk("R4 count resumes after clear", lo, 32'd4);
  endtask

  task automatic t_edge();
    logic [31:0] lo, hi;
    wr(cfg_a(1), 32'h0000_0C65);
    wr(A_CTRL, 32'h13);
    for (int k = 0; k < 4; k++) pulse('h65, 3);
    wr(A_CTRL, 32'h0);
    peek(1, lo, hi);
    chk("R7 rising edges counted once each", lo, 32'd4);
  endtask

  task automatic t_polarity();
    logic [31:0] lo, hi;
    evt_in['h105] = 1'b1;
    evt_in['h12D] = 1'b1;
    wr(cfg_a(2), 32'h0000_0105);
    wr(cfg_a(3), 32'h0000_092D);
    wr(A_CTRL, 32'h13);
    low_pulse('h105, 5);
    low_pulse('h12D, 2);
    low_pulse('h12D, 1);
    wr(A_CTRL, 32'h0);
    peek(2, lo, hi);
    chk("R8 active-low level count", lo, 32'd5);
    peek(3, lo, hi);
    chk("R8 falling edge count", lo, 32'd2);
  endtask

  task automatic t_snapshot();
    logic [31:0] lo, hi;
    wr(cfg_a(0), 32'h0000_043D);
    evt_in['h3D] = 1'b1;
    wr(A_CTRL, 32'h13);
    repeat (5) @(posedge clk);
    wr(A_SEL, 32'd8);
    rd(A_WLO, lo);
    chk("R10 snapshot value", lo, 32'd5);
    repeat (3) @(posedge clk);
    rd(A_WLO, lo);
    chk("R10 snapshot holds while counting", lo, 32'd5);
    rd(A_WHI, hi);
    chk("R10 snapshot hi", hi, 32'd0);
    evt_in['h3D] = 1'b0;
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_badsel();
    logic [31:0] d;
    wr(A_SEL, 32'd8);
    wr(A_SEL, 32'd7);
    rd(A_WLO, d); chk("R11 select 7 lo", d, 32'd0);
    rd(A_WHI, d); chk("R11 select 7 hi", d, 32'd0);
    rd(A_SEL, d); chk("R11 select readback", d, 32'd7);
    wr(A_SEL, 32'd8);
    wr(A_SEL, 32'd16);
    rd(A_WLO, d); chk("R11 select 16 lo", d, 32'd0);
  endtask

  task automatic t_badid();
    logic [31:0] lo, hi;
    wr(cfg_a(0), 32'h0000_063D);
    wr(A_CTRL, 32'h13);
    pulse('h3D, 6);
    wr(A_CTRL, 32'h0);
    peek(0, lo, hi);
    chk("R9 out-of-range id never counts", lo, 32'd0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] d;
    wr(cfg_a(5), 32'hFFFF_FFFF);
    rd(cfg_a(5), d); chk("R5 cfg5 width", d, 32'h0000_0FFF);
    rd(cfg_a(4), d); chk("R5 cfg4 untouched", d, 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_level();
    t_ctrl_gate();
    t_clear();
    t_edge();
    t_polarity();
    t_snapshot();
    t_badsel();
    t_badid();
    t_cfg_rw();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule